// File: doc/BRIEF.md
# Token-Passing Readout Sequencer

This block sequences one front-end chip through its bunch-train cycle. It covers acquisition, a fixed conversion interval, readout onto a data bus shared by a whole chain of chips, and a powered-down idle phase. A spill signal from the system frames acquisition. When spill falls, the chip latches how many events it holds and spends a fixed number of clocks converting. It then waits for the chain token.

When the token arrives, the chip reads its local event memory word by word and drives each word onto the shared bus at a paced rate. It then passes the token on in a single-cycle pulse. A chip that stored nothing forwards the token on the next clock without touching the bus. Whenever the chip is not sending, it releases the bus, so an external open-collector driver sees no drive. Once the token has left, the chip powers its analog section down until the next spill. A token that shows up at any other time is ignored and reported as an error.

Top module: `token_readout_seq`

## Requirements
- R1: While reset is asserted, and for the cycles until its release has been synchronised, power enable, bus enable, bus data, token out and the error flag are all 0.
- R2: In idle, a clock edge that sees spill high moves the chip to acquisition, and power enable is 1 from the following cycle.
- R3: The first edge during acquisition that sees spill low latches the event count, saturated at MAX_EVT. Conversion then lasts exactly CONV_CYCLES clocks before the chip waits for the token.
- R4: A token sampled while waiting with a non-zero count makes the bus enable 1 from the next cycle. Memory addresses 0, 1, 2 … are presented in order, each held for CLK_DIV clocks, and bus data equals the memory word at the current address.
- R5: The number of words sent equals the latched count times WORDS_PER_EVT, and the address never reaches that total.
- R6: Whenever bus enable is 0, bus data is all zeros (the line is released).
- R7: After the last word's final clock, token out is 1 for exactly one cycle, and bus enable is 0 in that cycle.
- R8: With a latched count of zero, a sampled token gives token out on the very next cycle, and the bus enable stays 0 throughout.
- R9: A token high on an edge where the chip is not waiting for it changes no behaviour. The error flag is 1 for the following cycle only.
- R10: Power enable falls in the cycle after token out and stays 0 until spill starts a new acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spill_i | input | 1 | High during acquisition |
| evt_count_i | input | $clog2(MAX_EVT+1)+1 | Stored event count, sampled at the end of spill |
| token_i | input | 1 | Token from the previous chip |
| token_o | output | 1 | One-cycle token to the next chip |
| mem_addr_o | output | AW | Word address into local event memory |
| mem_data_i | input | DATA_W | Memory word at mem_addr_o (combinational read) |
| bus_data_o | output | DATA_W | Data to the shared bus driver |
| bus_oe_o | output | 1 | Bus drive enable; 0 releases the line |
| pwr_en_o | output | 1 | Power-pulse enable for the analog section |
| token_err_o | output | 1 | Token seen outside the waiting phase |

## Verification
Every control output is a decode of the registered phase or a one-register flag, so each result is due exactly one clock after the edge that sampled the stimulus. Power comes up one cycle after spill is seen, and the bus is driven one cycle after the token. The error flag follows a stray token by one cycle. Token out follows the last word after total×CLK_DIV send clocks. The release of the reset synchroniser adds two cycles in which the block must look idle. The bench model advances its phase on every rising edge from the same inputs and compares all outputs on the falling edge, which is where each of these due cycles has settled.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACQ,
    PH_CONV,
    PH_WAIT,
    PH_SEND,
    PH_PASS
  } phase_t;
endpackage

// File: rtl/trs_phase_fsm.sv
module trs_phase_fsm
  import trs_pkg::*;
#(
  parameter int MAX_EVT       = 16,
  parameter int WORDS_PER_EVT = 225,
  parameter int CONV_CYCLES   = 20000,
  localparam int EIN_W = $clog2(MAX_EVT + 1) + 1,
  localparam int AW    = $clog2(MAX_EVT * WORDS_PER_EVT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spill_i,
  input  logic             token_i,
  input  logic [EIN_W-1:0] evt_count_i,
  input  logic             last_word_i,
  output phase_t           phase_o,
  output logic [AW-1:0]    total_o
);
  localparam int EW = $clog2(MAX_EVT + 1);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  phase_t        ph_q, ph_d;
  logic [EW-1:0] ev_q, ev_d;
  logic          ev_en;
  logic [CW-1:0] cc_q, cc_d;
  logic          cc_en;

  always_comb begin
    ph_d  = ph_q;
    ev_d  = ev_q;
    ev_en = 1'b0;
    cc_d  = cc_q;
    cc_en = 1'b0;
    case (ph_q)
      PH_IDLE: if (spill_i) ph_d = PH_ACQ;
      PH_ACQ: begin
        if (!spill_i) begin
          ph_d  = PH_CONV;
          cc_d  = '0;
          cc_en = 1'b1;
          ev_en = 1'b1;
          ev_d  = (evt_count_i > EIN_W'(MAX_EVT)) ? EW'(MAX_EVT) : EW'(evt_count_i);
        end
      end
      PH_CONV: begin
        if (cc_q == CW'(CONV_CYCLES - 1)) begin
          ph_d = PH_WAIT;
        end else begin
          cc_d  = cc_q + 1'b1;
          cc_en = 1'b1;
        end
      end
      PH_WAIT: if (token_i) ph_d = (ev_q == '0) ? PH_PASS : PH_SEND;
      PH_SEND: if (last_word_i) ph_d = PH_PASS;
      PH_PASS: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      ev_q <= '0;
      cc_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (ev_en) ev_q <= ev_d;
      if (cc_en) cc_q <= cc_d;
    end
  end

  assign phase_o = ph_q;
  assign total_o = AW'(ev_q) * AW'(WORDS_PER_EVT);

  AST_CONV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_CONV) |-> (cc_q < CW'(CONV_CYCLES))); // R3
  AST_SEND_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SEND && $past(ph_q) != PH_SEND) |-> $past(token_i)); // R4
  AST_COUNT_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q <= EW'(MAX_EVT)); // R3
endmodule

// File: rtl/trs_word_pacer.sv
module trs_word_pacer #(
  parameter int CLK_DIV = 8,
  parameter int AW      = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [AW-1:0] total_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam int DW = $clog2(CLK_DIV + 1);

  logic [DW-1:0] div_q, div_d;
  logic [AW-1:0] word_q, word_d;
  logic          tick;

  assign tick   = (div_q == DW'(CLK_DIV - 1));
  assign last_o = run_i && tick && (word_q == total_i - 1'b1);

  always_comb begin
    div_d  = div_q;
    word_d = word_q;
    if (!run_i) begin
      div_d  = '0;
      word_d = '0;
    end else if (tick) begin
      div_d  = '0;
      word_d = last_o ? word_q : word_q + 1'b1;
    end else begin
      div_d  = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      word_q <= '0;
    end else begin
      div_q  <= div_d;
      word_q <= word_d;
    end
  end

  assign addr_o = word_q;

  AST_WORD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (word_q < total_i)); // R5
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !$past(tick)) |-> $stable(word_q)); // R4
endmodule

// File: rtl/token_readout_seq.sv
module token_readout_seq
  import trs_pkg::*;
#(
  parameter int MAX_EVT       = 16,
  parameter int WORDS_PER_EVT = 225,
  parameter int CONV_CYCLES   = 20000,
  parameter int CLK_DIV       = 8,
  parameter int DATA_W        = 8,
  localparam int EIN_W = $clog2(MAX_EVT + 1) + 1,
  localparam int AW    = $clog2(MAX_EVT * WORDS_PER_EVT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spill_i,
  input  logic [EIN_W-1:0]  evt_count_i,
  input  logic              token_i,
  output logic              token_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o,
  output logic              pwr_en_o,
  output logic              token_err_o
);
  logic [1:0]    rs_q;
  logic          rst_s_n;
  phase_t        phase;
  logic [AW-1:0] total;
  logic          last_word;
  logic          err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  trs_phase_fsm #(
    .MAX_EVT(MAX_EVT), .WORDS_PER_EVT(WORDS_PER_EVT), .CONV_CYCLES(CONV_CYCLES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .spill_i(spill_i), .token_i(token_i),
    .evt_count_i(evt_count_i), .last_word_i(last_word),
    .phase_o(phase), .total_o(total)
  );

  trs_word_pacer #(.CLK_DIV(CLK_DIV), .AW(AW)) u_pacer (
    .clk(clk), .rst_n(rst_s_n), .run_i(phase == PH_SEND), .total_i(total),
    .addr_o(mem_addr_o), .last_o(last_word)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) err_q <= 1'b0;
    else          err_q <= token_i && (phase != PH_WAIT);
  end

  assign token_o     = (phase == PH_PASS);
  assign bus_oe_o    = (phase == PH_SEND);
  assign bus_data_o  = bus_oe_o ? mem_data_i : '0;
  assign pwr_en_o    = (phase != PH_IDLE);
  assign token_err_o = err_q;

  AST_TOKEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    token_o |=> !token_o); // R7
  AST_PASS_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_s_n)
    token_o |-> !bus_oe_o); // R7
  AST_POWER_DOWN_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_s_n)
    token_o |=> !pwr_en_o); // R10
  AST_ERR_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_s_n)
    token_err_o |-> $past(token_i)); // R9
  AST_WAKE_ON_SPILL: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(pwr_en_o) |-> $past(spill_i)); // R2
endmodule

// File: tb/tb_token_readout_seq.sv
module tb_token_readout_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_EVT = 16;
  localparam int WPE     = 3;
  localparam int CONV    = 5;
  localparam int DIV     = 2;
  localparam int DW      = 8;
  localparam int EIN_W   = $clog2(MAX_EVT + 1) + 1;
  localparam int AW      = $clog2(MAX_EVT * WPE + 1);
  localparam int WDOG    = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spill = 1'b0;
  logic [EIN_W-1:0] evt = '0;
  logic tok_in = 1'b0;
  logic tok_out, oe, pwr, err;
  logic [AW-1:0] addr;
  logic [DW-1:0] mdata, bdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign mdata = DW'(addr) * 8'd7 + 8'd3;

  token_readout_seq #(
    .MAX_EVT(MAX_EVT), .WORDS_PER_EVT(WPE), .CONV_CYCLES(CONV),
    .CLK_DIV(DIV), .DATA_W(DW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .spill_i(spill), .evt_count_i(evt),
    .token_i(tok_in), .token_o(tok_out), .mem_addr_o(addr),
    .mem_data_i(mdata), .bus_data_o(bdata), .bus_oe_o(oe),
    .pwr_en_o(pwr), .token_err_o(err)
  );

  // behavioural reference: 0 idle, 1 acq, 2 conv, 3 wait, 4 send, 5 pass
  int m_st = 0, m_cc = 0, m_ev = 0, m_wc = 0, m_dc = 0;
  bit m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_err = 0; m_cc = 0; m_ev = 0; m_wc = 0; m_dc = 0;
    end else begin
      m_err = tok_in && (m_st != 3);
      case (m_st)
        0: if (spill) m_st = 1;
        1: if (!spill) begin
             m_ev = (int'(evt) > MAX_EVT) ? MAX_EVT : int'(evt);
             m_cc = 0;
             m_st = 2;
           end
        2: if (m_cc == CONV - 1) m_st = 3; else m_cc++;
        3: if (tok_in) begin
             m_st = (m_ev == 0) ? 5 : 4;
             m_wc = 0;
             m_dc = 0;
           end
        4: if (m_dc == DIV - 1) begin
             m_dc = 0;
             if (m_wc == m_ev * WPE - 1) m_st = 5; else m_wc++;
           end else m_dc++;
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 pwr_en", int'(pwr), 0);
      chk("R1 bus_oe", int'(oe), 0);
      chk("R1 token_o", int'(tok_out), 0);
      chk("R1 token_err", int'(err), 0);
    end else begin
      chk("R2 R10 pwr_en", int'(pwr), (m_st != 0) ? 1 : 0);
      chk("R4 R8 bus_oe", int'(oe), (m_st == 4) ? 1 : 0);
      chk("R4 R6 bus_data", int'(bdata), (m_st == 4) ? ((m_wc * 7 + 3) & 255) : 0);
      if (m_st == 4) chk("R5 mem_addr", int'(addr), m_wc);
      chk("R3 R7 R8 token_o", int'(tok_out), (m_st == 5) ? 1 : 0);
      chk("R9 token_err", int'(err), int'(m_err));
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_token();
    @(negedge clk); tok_in = 1'b1;
    @(negedge clk); tok_in = 1'b0;
  endtask

  task automatic run_train(int count, bit stray);
    int sat;
    sat = (count > MAX_EVT) ? MAX_EVT : count;
    if (stray) pulse_token();          // R9: token in idle
    @(negedge clk); spill = 1'b1; evt = EIN_W'(count);
    cycles(3);
    if (stray) pulse_token();          // R9: token during acquisition
    cycles(3);
    @(negedge clk); spill = 1'b0;
    cycles(CONV + 3);
    pulse_token();                     // R4 R8: the real token
    if (stray && sat > 0) begin
      cycles(1);
      pulse_token();                   // R9: token while sending
    end
    cycles(sat * WPE * DIV + 6);       // R10: idle, powered down
  endtask

  initial begin
    fork
      begin
        cycles(4);
        @(negedge clk); rst_n = 1'b1;
        cycles(6);
        run_train(2, 1'b0);            // R4 R5 R7
        run_train(0, 1'b0);            // R8
        run_train(20, 1'b0);           // R3 saturation
        run_train(1, 1'b1);            // R9
        run_train(5, 1'b0);
        cycles(4);
      end
      begin
        repeat (WDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule